// File: doc/BRIEF.md
# Half-Duplex Link Byte Buffer with Interrupt

This block is one byte FIFO shared by both directions of a half-duplex radio link. A host controller sits on one side and a modem on the other. A 2-bit link-mode setting picks which side fills the buffer and which side drains it. In transmit, the host loads payload bytes and the modem takes them. In either receive mode, the modem deposits bytes and the host collects them. In idle, no byte moves in either direction.

An active-high interrupt line tells the host when to act. A 2-bit interrupt-select code controls it, and the code means different things in each direction. In receive, the codes are fill watermarks of 4, 8 or 12 bytes, or "errors only", and a modem-reported receive error interrupts under every code. In transmit, the codes are low-water marks of 4, 8 or 12 remaining bytes, each of which also fires on empty, or "empty only".

All four byte ports use valid/ready. Back-pressure comes only from the link mode. A port's ready is high whenever the current mode grants that port to its side, whatever the fill level. A push beat that arrives while the buffer is full is discarded and recorded in a sticky overflow flag. On the draining side, valid follows "granted and not empty". If the consumer raises ready while the buffer is empty, this counts as an underflow and is recorded the same way. Control and status pins are plain levels and strobes.

Top module: `hdx_byte_buffer`

## Requirements
- R1: After reset the link mode is idle (00), the interrupt-select code is 10, the fill level is 0, and irq, rx_error, overflow and underflow are all 0.
- R2: Mode 01 (transmit) sets host_wr_ready and lets mdm_tx_valid follow "not empty". Modes 10 and 11 (receive) set mdm_rx_ready and let host_rd_valid follow "not empty". The other two handshake signals are held low.
- R3: In mode 00 (idle), host_wr_ready, mdm_rx_ready, host_rd_valid and mdm_tx_valid are all low, the fill level does not change, and irq is low.
- R4: Bytes leave in the order they were accepted. fill_level reports the number held, from 0 to DEPTH (16). A push and a pop in the same cycle are both judged against the fill level before that cycle.
- R5: A push beat that arrives while the fill level is DEPTH is discarded and sets overflow. Overflow stays set until a status read.
- R6: If the draining side raises ready while the buffer is empty and the mode grants that side, nothing is removed and underflow is set. Underflow stays set until a status read.
- R7: In receive modes, interrupt-select codes 00, 01 and 10 raise irq while the fill level is at least 4, 8 or 12 respectively.
- R8: In receive modes, irq is high while rx_error is set, under every code. Code 11 raises irq on rx_error only and never on fill level.
- R9: In transmit mode, codes 00, 01 and 10 raise irq while the fill level is at most 4, 8 or 12 respectively. The empty case is included.
- R10: In transmit mode, code 11 raises irq only while the buffer is empty.
- R11: A mdm_rx_err pulse in a receive mode sets rx_error. The stat_rd strobe clears rx_error, overflow and underflow. A set and a clear in the same cycle leave the flag set.
- R12: A cfg_we that loads a different mode than the current one empties the buffer and clears rx_error, and all beats in that cycle are discarded. A cfg_we that keeps the same mode changes only the interrupt-select code.
- R13: irq is a level taken from the current mode, code, fill level and rx_error. It drops in the cycle after its condition stops holding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load cfg_mode and cfg_irq_sel |
| cfg_mode | input | 2 | Link mode: 00 idle, 01 transmit, 10 receive-polling, 11 receive |
| cfg_irq_sel | input | 2 | Interrupt-select code |
| stat_rd | input | 1 | Status read strobe; clears the sticky flags |
| host_wr_valid | input | 1 | Host push beat valid (transmit) |
| host_wr_ready | output | 1 | Host push granted |
| host_wr_data | input | 8 | Host push byte |
| host_rd_valid | output | 1 | Byte available to host (receive) |
| host_rd_ready | input | 1 | Host takes the head byte |
| host_rd_data | output | 8 | Head byte |
| mdm_rx_valid | input | 1 | Modem push beat valid (receive) |
| mdm_rx_ready | output | 1 | Modem push granted |
| mdm_rx_data | input | 8 | Modem push byte |
| mdm_rx_err | input | 1 | Modem receive-error pulse |
| mdm_tx_valid | output | 1 | Byte available to modem (transmit) |
| mdm_tx_ready | input | 1 | Modem takes the head byte |
| mdm_tx_data | output | 8 | Head byte |
| cur_mode | output | 2 | Current link mode |
| cur_irq_sel | output | 2 | Current interrupt-select code |
| fill_level | output | 5 | Bytes held |
| rx_error | output | 1 | Sticky receive-error flag |
| overflow | output | 1 | Sticky dropped-push flag |
| underflow | output | 1 | Sticky empty-pop flag |
| irq | output | 1 | Interrupt, active high |

## Verification
The hardest state to reach from the ports is one where three things hold at once: a full buffer, a push and a pop landing in the same cycle, and a mode change or status read in that cycle or the one after. Only then do the pre-cycle fullness rule and the flush priority both show up. The random stimulus runs in alternating fill-heavy and drain-heavy phases, so the fill level keeps sweeping between 0 and 16. Rare mode rewrites and frequent status reads are mixed in at random points, and directed sequences first force overflow, underflow, flush-on-change and the receive-error interrupt.

// File: rtl/hdx_buf_pkg.sv
`timescale 1ns/1ps
package hdx_buf_pkg;

  typedef enum logic [1:0] {
    LINK_IDLE   = 2'b00,
    LINK_TX     = 2'b01,
    LINK_RXPOLL = 2'b10,
    LINK_RX     = 2'b11
  } link_mode_e;

  typedef enum logic [1:0] {
    IRQ_WM_LOW  = 2'b00,
    IRQ_WM_MID  = 2'b01,
    IRQ_WM_HIGH = 2'b10,
    IRQ_EVENT   = 2'b11
  } irq_sel_e;

  function automatic logic mode_is_rx(input link_mode_e m);
    return (m == LINK_RXPOLL) || (m == LINK_RX);
  endfunction

  function automatic logic mode_is_tx(input link_mode_e m);
    return m == LINK_TX;
  endfunction

endpackage

// File: rtl/hdx_fifo_core.sv
`timescale 1ns/1ps
module hdx_fifo_core #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_drop
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push && !full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign push_drop = push && full && !flush;
  assign pop_drop  = pop && empty && !flush;
  assign head_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/hdx_port_route.sv
`timescale 1ns/1ps
module hdx_port_route
  import hdx_buf_pkg::*;
#(
  parameter int DW = 8
) (
  input  link_mode_e    mode,
  input  logic          empty,
  input  logic [DW-1:0] head_data,
  input  logic          host_wr_valid,
  input  logic [DW-1:0] host_wr_data,
  output logic          host_wr_ready,
  output logic          host_rd_valid,
  input  logic          host_rd_ready,
  output logic [DW-1:0] host_rd_data,
  input  logic          mdm_rx_valid,
  input  logic [DW-1:0] mdm_rx_data,
  output logic          mdm_rx_ready,
  output logic          mdm_tx_valid,
  input  logic          mdm_tx_ready,
  output logic [DW-1:0] mdm_tx_data,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic          pop
);

  logic tx_dir, rx_dir;

  assign tx_dir = mode_is_tx(mode);
  assign rx_dir = mode_is_rx(mode);

  assign host_wr_ready = tx_dir;
  assign mdm_rx_ready  = rx_dir;
  assign mdm_tx_valid  = tx_dir && !empty;
  assign host_rd_valid = rx_dir && !empty;
  assign host_rd_data  = head_data;
  assign mdm_tx_data   = head_data;

  always_comb begin
    push      = 1'b0;
    pop       = 1'b0;
    push_data = host_wr_data;
    if (tx_dir) begin
      push = host_wr_valid;
      pop  = mdm_tx_ready;
    end else if (rx_dir) begin
      push      = mdm_rx_valid;
      push_data = mdm_rx_data;
      pop       = host_rd_ready;
    end
  end

endmodule

// File: rtl/hdx_irq_eval.sv
`timescale 1ns/1ps
module hdx_irq_eval
  import hdx_buf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int WM_STEP = 4,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  link_mode_e    mode,
  input  irq_sel_e      sel,
  input  logic [CW-1:0] count,
  input  logic          rx_err,
  output logic          irq
);

  logic [CW-1:0] thr;
  logic          wm_on;

  always_comb begin
    thr   = CW'((32'(sel) + 32'd1) * WM_STEP);
    wm_on = (sel != IRQ_EVENT);
    case (mode)
      LINK_TX:             irq = (count == '0) || (wm_on && (count <= thr));
      LINK_RXPOLL, LINK_RX: irq = rx_err || (wm_on && (count >= thr));
      default:             irq = 1'b0;
    endcase
  end

endmodule

// File: rtl/hdx_byte_buffer.sv
`timescale 1ns/1ps
module hdx_byte_buffer
  import hdx_buf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DW      = 8,
  parameter int WM_STEP = 4,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_irq_sel,
  input  logic          stat_rd,
  input  logic          host_wr_valid,
  output logic          host_wr_ready,
  input  logic [DW-1:0] host_wr_data,
  output logic          host_rd_valid,
  input  logic          host_rd_ready,
  output logic [DW-1:0] host_rd_data,
  input  logic          mdm_rx_valid,
  output logic          mdm_rx_ready,
  input  logic [DW-1:0] mdm_rx_data,
  input  logic          mdm_rx_err,
  output logic          mdm_tx_valid,
  input  logic          mdm_tx_ready,
  output logic [DW-1:0] mdm_tx_data,
  output logic [1:0]    cur_mode,
  output logic [1:0]    cur_irq_sel,
  output logic [CW-1:0] fill_level,
  output logic          rx_error,
  output logic          overflow,
  output logic          underflow,
  output logic          irq
);

  link_mode_e    mode_q;
  irq_sel_e      sel_q;
  logic          flush;
  logic          push, pop, empty, push_drop, pop_drop;
  logic [DW-1:0] push_data, head_data;
  logic [CW-1:0] count;
  logic          err_q, ovf_q, unf_q;

  assign flush = cfg_we && (link_mode_e'(cfg_mode) != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LINK_IDLE;
      sel_q  <= IRQ_WM_HIGH;
    end else if (cfg_we) begin
      mode_q <= link_mode_e'(cfg_mode);
      sel_q  <= irq_sel_e'(cfg_irq_sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      err_q <= flush ? 1'b0
                     : ((err_q && !stat_rd) || (mode_is_rx(mode_q) && mdm_rx_err));
      ovf_q <= (ovf_q && !stat_rd) || push_drop;
      unf_q <= (unf_q && !stat_rd) || pop_drop;
    end
  end

  hdx_port_route #(.DW(DW)) u_route (
    .mode          (mode_q),
    .empty         (empty),
    .head_data     (head_data),
    .host_wr_valid (host_wr_valid),
    .host_wr_data  (host_wr_data),
    .host_wr_ready (host_wr_ready),
    .host_rd_valid (host_rd_valid),
    .host_rd_ready (host_rd_ready),
    .host_rd_data  (host_rd_data),
    .mdm_rx_valid  (mdm_rx_valid),
    .mdm_rx_data   (mdm_rx_data),
    .mdm_rx_ready  (mdm_rx_ready),
    .mdm_tx_valid  (mdm_tx_valid),
    .mdm_tx_ready  (mdm_tx_ready),
    .mdm_tx_data   (mdm_tx_data),
    .push          (push),
    .push_data     (push_data),
    .pop           (pop)
  );

  hdx_fifo_core #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .head_data (head_data),
    .count     (count),
    .empty     (empty),
    .push_drop (push_drop),
    .pop_drop  (pop_drop)
  );

  hdx_irq_eval #(.DEPTH(DEPTH), .WM_STEP(WM_STEP)) u_irq (
    .mode   (mode_q),
    .sel    (sel_q),
    .count  (count),
    .rx_err (err_q),
    .irq    (irq)
  );

  assign cur_mode    = mode_q;
  assign cur_irq_sel = sel_q;
  assign fill_level  = count;
  assign rx_error    = err_q;
  assign overflow    = ovf_q;
  assign underflow   = unf_q;

endmodule

// File: rtl/hdx_byte_buffer_chk.sv
`timescale 1ns/1ps
module hdx_byte_buffer_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_mode,
  input logic          host_wr_valid,
  input logic          host_wr_ready,
  input logic          host_rd_valid,
  input logic          host_rd_ready,
  input logic          mdm_rx_valid,
  input logic          mdm_rx_ready,
  input logic          mdm_tx_valid,
  input logic          mdm_tx_ready,
  input logic [1:0]    cur_mode,
  input logic [1:0]    cur_irq_sel,
  input logic [CW-1:0] fill_level,
  input logic          rx_error,
  input logic          overflow,
  input logic          underflow,
  input logic          irq
);

  logic chg, prod_beat, cons_req, in_rx, in_tx;
  assign chg       = cfg_we && (cfg_mode != cur_mode);
  assign in_rx     = cur_mode[1];
  assign in_tx     = (cur_mode == 2'b01);
  assign prod_beat = (in_tx && host_wr_valid) || (in_rx && mdm_rx_valid);
  assign cons_req  = (in_tx && mdm_tx_ready) || (in_rx && host_rd_ready);

  p_idle_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b00) |-> (!host_wr_ready && !mdm_rx_ready && !host_rd_valid
                             && !mdm_tx_valid && !irq));

  p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CW'(DEPTH));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_beat && fill_level == CW'(DEPTH) && !chg) |=> (overflow && fill_level != '0));

  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_req && fill_level == '0 && !chg) |=> underflow);

  p_rx_err_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rx && rx_error) |-> irq);

  p_tx_empty_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tx && fill_level == '0) |-> irq);

  p_tx_event_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tx && cur_irq_sel == 2'b11 && fill_level != '0) |-> !irq);

  p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (fill_level == '0 && !rx_error));

endmodule

bind hdx_byte_buffer hdx_byte_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .cfg_mode      (cfg_mode),
  .host_wr_valid (host_wr_valid),
  .host_wr_ready (host_wr_ready),
  .host_rd_valid (host_rd_valid),
  .host_rd_ready (host_rd_ready),
  .mdm_rx_valid  (mdm_rx_valid),
  .mdm_rx_ready  (mdm_rx_ready),
  .mdm_tx_valid  (mdm_tx_valid),
  .mdm_tx_ready  (mdm_tx_ready),
  .cur_mode      (cur_mode),
  .cur_irq_sel   (cur_irq_sel),
  .fill_level    (fill_level),
  .rx_error      (rx_error),
  .overflow      (overflow),
  .underflow     (underflow),
  .irq           (irq)
);

// File: tb/hdx_byte_buffer_test.sv
`timescale 1ns/1ps
module hdx_byte_buffer_test;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 0, stat_rd = 0;
  logic [1:0] cfg_mode = 0, cfg_irq_sel = 0;
  logic       host_wr_valid = 0, host_rd_ready = 0, mdm_rx_valid = 0;
  logic       mdm_rx_err = 0, mdm_tx_ready = 0;
  logic [7:0] host_wr_data = 0, mdm_rx_data = 0;
  logic       host_wr_ready, host_rd_valid, mdm_rx_ready, mdm_tx_valid;
  logic [7:0] host_rd_data, mdm_tx_data;
  logic [1:0] cur_mode, cur_irq_sel;
  logic [4:0] fill_level;
  logic       rx_error, overflow, underflow, irq;

  always #5 clk = ~clk;

  hdx_byte_buffer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_irq_sel(cfg_irq_sel), .stat_rd(stat_rd),
    .host_wr_valid(host_wr_valid), .host_wr_ready(host_wr_ready),
    .host_wr_data(host_wr_data), .host_rd_valid(host_rd_valid),
    .host_rd_ready(host_rd_ready), .host_rd_data(host_rd_data),
    .mdm_rx_valid(mdm_rx_valid), .mdm_rx_ready(mdm_rx_ready),
    .mdm_rx_data(mdm_rx_data), .mdm_rx_err(mdm_rx_err),
    .mdm_tx_valid(mdm_tx_valid), .mdm_tx_ready(mdm_tx_ready),
    .mdm_tx_data(mdm_tx_data), .cur_mode(cur_mode), .cur_irq_sel(cur_irq_sel),
    .fill_level(fill_level), .rx_error(rx_error), .overflow(overflow),
    .underflow(underflow), .irq(irq)
  );

  int n_total = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] mq[$];
  logic [1:0] m_mode = 0, m_sel = 2'b10;
  bit         m_err = 0, m_ovf = 0, m_unf = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_irq();
    int n = mq.size();
    int thr = (int'(m_sel) + 1) * 4;
    if (m_mode == 2'b01) return (n == 0) || (m_sel != 2'b11 && n <= thr);
    if (m_mode[1])       return m_err || (m_sel != 2'b11 && n >= thr);
    return 0;
  endfunction

  function automatic string irq_tag();
    if (m_mode == 2'b00) return "R3";
    if (m_mode == 2'b01) return (m_sel == 2'b11) ? "R10" : "R9";
    return (m_sel == 2'b11 || m_err) ? "R8" : "R7";
  endfunction

  task automatic compare();
    bit tx = (m_mode == 2'b01);
    bit rx = m_mode[1];
    string gt = (m_mode == 2'b00) ? "R3" : "R2";
    bit ne = (mq.size() != 0);
    check(irq_tag(), "irq", irq, exp_irq());
    check("R4", "fill_level", fill_level, mq.size());
    check(gt, "host_wr_ready", host_wr_ready, tx);
    check(gt, "mdm_rx_ready", mdm_rx_ready, rx);
    check(gt, "mdm_tx_valid", mdm_tx_valid, tx && ne);
    check(gt, "host_rd_valid", host_rd_valid, rx && ne);
    if (ne) begin
      if (tx) check("R4", "mdm_tx_data", mdm_tx_data, mq[0]);
      if (rx) check("R4", "host_rd_data", host_rd_data, mq[0]);
    end
    check("R11", "rx_error", rx_error, m_err);
    check("R5", "overflow", overflow, m_ovf);
    check("R6", "underflow", underflow, m_unf);
    check("R12", "cur_mode", cur_mode, m_mode);
    check("R12", "cur_irq_sel", cur_irq_sel, m_sel);
  endtask

  task automatic model_update();
    bit tx = (m_mode == 2'b01);
    bit rx = m_mode[1];
    bit fl = cfg_we && (cfg_mode != m_mode);
    bit push = tx ? host_wr_valid : (rx ? mdm_rx_valid : 1'b0);
    bit pop  = tx ? mdm_tx_ready : (rx ? host_rd_ready : 1'b0);
    logic [7:0] d = tx ? host_wr_data : mdm_rx_data;
    int n = mq.size();
    if (fl) begin
      mq.delete();
      m_err = 0;
      m_ovf = m_ovf && !stat_rd;
      m_unf = m_unf && !stat_rd;
    end else begin
      if (pop && n > 0) void'(mq.pop_front());
      if (push && n < DEPTH) mq.push_back(d);
      m_ovf = (m_ovf && !stat_rd) || (push && n == DEPTH);
      m_unf = (m_unf && !stat_rd) || (pop && n == 0);
      m_err = (m_err && !stat_rd) || (rx && mdm_rx_err);
    end
    if (cfg_we) begin
      m_mode = cfg_mode;
      m_sel  = cfg_irq_sel;
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
    @(posedge clk);
    model_update();
    #1;
  endtask

  task automatic idle_inputs();
    cfg_we = 0; stat_rd = 0; host_wr_valid = 0; host_rd_ready = 0;
    mdm_rx_valid = 0; mdm_rx_err = 0; mdm_tx_ready = 0;
  endtask

  task automatic set_cfg(input logic [1:0] md, input logic [1:0] sl);
    idle_inputs();
    cfg_we = 1; cfg_mode = md; cfg_irq_sel = sl;
    cyc();
    cfg_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R1", "mode after reset", cur_mode, 0);
    check("R1", "irq_sel after reset", cur_irq_sel, 2);
    check("R1", "fill after reset", fill_level, 0);
    check("R1", "irq after reset", irq, 0);
    check("R1", "flags after reset", {rx_error, overflow, underflow}, 0);
    @(posedge clk); #1;

    // Idle: all beats refused
    idle_inputs();
    host_wr_valid = 1; mdm_rx_valid = 1; host_rd_ready = 1; mdm_tx_ready = 1;
    repeat (3) cyc();
    check("R3", "idle fill unchanged", fill_level, 0);
    check("R3", "idle underflow untouched", underflow, 0);

    // Receive, watermark 4, fill past full
    set_cfg(2'b11, 2'b00);
    for (int i = 0; i < 17; i++) begin
      idle_inputs(); mdm_rx_valid = 1; mdm_rx_data = 8'(i + 8'h40);
      cyc();
    end
    idle_inputs();
    cyc();
    check("R5", "overflow after 17th push", overflow, 1);
    check("R4", "fill at depth", fill_level, 16);
    stat_rd = 1; cyc(); stat_rd = 0;
    check("R11", "overflow cleared by status read", overflow, 0);
    for (int i = 0; i < 17; i++) begin
      idle_inputs(); host_rd_ready = 1;
      cyc();
    end
    idle_inputs(); cyc();
    check("R6", "underflow after draining", underflow, 1);
    check("R13", "irq dropped once below watermark", irq, 0);

    // Receive error with event-only code
    set_cfg(2'b11, 2'b11);
    mdm_rx_err = 1; cyc(); mdm_rx_err = 0; cyc();
    check("R8", "irq on receive error", irq, 1);
    stat_rd = 1; cyc(); stat_rd = 0; cyc();
    check("R11", "rx_error cleared", rx_error, 0);
    check("R8", "irq gone after clear", irq, 0);

    // Transmit, empty-only
    set_cfg(2'b01, 2'b11);
    cyc();
    check("R10", "irq on empty tx", irq, 1);
    for (int i = 0; i < 5; i++) begin
      idle_inputs(); host_wr_valid = 1; host_wr_data = 8'(8'hA0 + i);
      cyc();
    end
    idle_inputs(); cyc();
    check("R10", "no irq with bytes waiting", irq, 0);
    set_cfg(2'b01, 2'b00);
    cyc();
    check("R12", "same-mode write keeps bytes", fill_level, 5);
    set_cfg(2'b10, 2'b10);
    cyc();
    check("R12", "mode change flushes", fill_level, 0);

    // Constrained random
    for (int ph = 0; ph < 60; ph++) begin
      bit filling = ph[0];
      for (int k = 0; k < 64; k++) begin
        idle_inputs();
        if ($urandom_range(0, 149) == 0) begin
          cfg_we = 1; cfg_mode = 2'($urandom); cfg_irq_sel = 2'($urandom);
        end else if ($urandom_range(0, 39) == 0) begin
          cfg_we = 1; cfg_mode = m_mode; cfg_irq_sel = 2'($urandom);
        end
        if (m_mode == 2'b00 && !cfg_we && $urandom_range(0, 9) == 0) begin
          cfg_we = 1; cfg_mode = 2'($urandom_range(1, 3)); cfg_irq_sel = 2'($urandom);
        end
        host_wr_valid = ($urandom_range(0, 9) < (filling ? 7 : 2));
        mdm_rx_valid  = ($urandom_range(0, 9) < (filling ? 7 : 2));
        host_rd_ready = ($urandom_range(0, 9) < (filling ? 2 : 7));
        mdm_tx_ready  = ($urandom_range(0, 9) < (filling ? 2 : 7));
        host_wr_data  = 8'($urandom);
        mdm_rx_data   = 8'($urandom);
        mdm_rx_err    = ($urandom_range(0, 49) == 0);
        stat_rd       = ($urandom_range(0, 29) == 0);
        cyc();
      end
    end
    idle_inputs();
    cyc();

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule